// File: doc/BRIEF.md
# Operate Unit with Condition Codes

This execute stage serves a 16-bit machine with eight general registers. It takes a decoded instruction word and the two register values that the register file has already read out. It works out the result of an add, a bitwise AND or a bitwise NOT, and it passes back the register indices the instruction names. For the operate opcodes it raises a destination write enable. The result and the write enable are combinational, so the register file can capture the result on the same clock edge.

The stage holds a 16-bit status word. The low three bits of that word are a one-hot negative/zero/positive flag triple, and the triple is rewritten on the clock edge after every operate instruction. A separate load port lets the load path report the value it wrote, so that load-class instructions set the flags as well. All other instructions leave the flags unchanged. The mode bit and the priority field of the status word keep the constant values set by parameters.

Top module: `opstage_nzp`

## Requirements
- R1: With opcode 0001 (instr[15:12]) and instr[5]=0, `result` is `opnd_a + opnd_b` modulo 2^16, with no carry or overflow kept.
- R2: With instr[5]=1, the second operand of ADD and AND is instr[4:0] taken as a two's complement value from -16 to 15 and sign-extended to 16 bits, and `opnd_b` is ignored.
- R3: With opcode 0101 and instr[5]=0, `result` is the bitwise AND of `opnd_a` and `opnd_b`.
- R4: With opcode 1001, `result` is the bitwise inverse of `opnd_a`.
- R5: `dst_idx` is instr[11:9], `src1_idx` is instr[8:6] and `src2_idx` is instr[2:0].
- R6: `wr_en` is 1 only when `valid` is 1 and the opcode is 0001, 0101 or 1001. It is 0 for every other opcode and whenever `valid` is 0.
- R7: On the clock edge after a write (`wr_en`=1), `status[2:0]` becomes one-hot: bit 2 (N) if result bit 15 is 1, bit 1 (Z) if the result is zero, and bit 0 (P) otherwise.
- R8: When `ld_en` is 1, the next edge sets the flags by the R7 rule from `ld_data`. In a cycle where a write also happens, `ld_data` decides the flags.
- R9: With `wr_en`=0 and `ld_en`=0, `status` does not change.
- R10: Reset sets the flags to Z (`status[2:0]`=010). `status[15]` is RST_MODE, `status[10:8]` is RST_PRIO, and the other bits are 0. With the default parameters the reset word is 0x8002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | An instruction is present this cycle |
| instr | input | 16 | Decoded instruction word |
| opnd_a | input | 16 | Value of the first source register |
| opnd_b | input | 16 | Value of the second source register |
| ld_en | input | 1 | The load path wrote a register this cycle |
| ld_data | input | 16 | Value the load path wrote |
| result | output | 16 | Operate result |
| dst_idx | output | 3 | Destination register index |
| src1_idx | output | 3 | First source register index |
| src2_idx | output | 3 | Second source register index |
| wr_en | output | 1 | Destination write enable |
| status | output | 16 | Status word, flags in bits [2:0] |

## Verification
The only internal state is the flag triple, and it is visible on `status` one edge after the instruction or load that wrote it. A flag that is wrong, not one-hot, or left over from an earlier instruction therefore shows up at the first sample after that edge. The checks also look for the error that persists: a flag that should have held through idle cycles or unsupported opcodes but moved. Errors in result or enable decoding are combinational and show up in the same cycle the instruction is presented.

// File: rtl/opstage_nzp.sv
module opstage_nzp #(
  parameter logic       RST_MODE = 1'b1,
  parameter logic [2:0] RST_PRIO = 3'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic [15:0] instr,
  input  logic [15:0] opnd_a,
  input  logic [15:0] opnd_b,
  input  logic        ld_en,
  input  logic [15:0] ld_data,
  output logic [15:0] result,
  output logic [2:0]  dst_idx,
  output logic [2:0]  src1_idx,
  output logic [2:0]  src2_idx,
  output logic        wr_en,
  output logic [15:0] status
);
  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_AND = 4'b0101;
  localparam logic [3:0] OP_NOT = 4'b1001;
  localparam logic [2:0] CC_RST = 3'b010;

  logic [15:0] lit, op_b, cc_src;
  logic        is_op;
  logic [2:0]  cc_q, cc_d;

  assign dst_idx  = instr[11:9];
  assign src1_idx = instr[8:6];
  assign src2_idx = instr[2:0];
  assign lit      = {{11{instr[4]}}, instr[4:0]};
  assign op_b     = instr[5] ? lit : opnd_b;

  always_comb begin
    is_op  = 1'b1;
    result = '0;
    case (instr[15:12])
      OP_ADD:  result = opnd_a + op_b;
      OP_AND:  result = opnd_a & op_b;
      OP_NOT:  result = ~opnd_a;
      default: is_op = 1'b0;
    endcase
  end

  assign wr_en  = valid & is_op;
  assign cc_src = ld_en ? ld_data : result;
  assign cc_d   = {cc_src[15], cc_src == '0, !cc_src[15] && cc_src != '0};

  always_ff @(posedge clk) begin
    if (!rst_n)              cc_q <= CC_RST;
    else if (ld_en || wr_en) cc_q <= cc_d;
  end

  assign status = {RST_MODE, 4'b0000, RST_PRIO, 5'b00000, cc_q};
endmodule

// File: rtl/opstage_nzp_chk.sv
module opstage_nzp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        ld_en,
  input logic [15:0] ld_data,
  input logic [15:0] result,
  input logic        wr_en,
  input logic [15:0] status
);
  assert_cc_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(status[2:0]) == 1);

  assert_idle_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !wr_en);

  assert_cc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !ld_en) |=> $stable(status));

  assert_load_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_data == 16'h0) |=> status[1]);

  assert_load_neg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_data[15]) |=> status[2]);

  assert_write_neg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_en && result[15]) |=> status[2]);
endmodule

bind opstage_nzp opstage_nzp_chk chk_i (
  .clk(clk), .rst_n(rst_n), .valid(valid), .ld_en(ld_en), .ld_data(ld_data),
  .result(result), .wr_en(wr_en), .status(status)
);

// File: tb/opstage_nzp_tb_top.sv
module opstage_nzp_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] opnd_a = '0;
  logic [15:0] opnd_b = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_data = '0;
  logic [15:0] result;
  logic [2:0]  dst_idx, src1_idx, src2_idx;
  logic        wr_en;
  logic [15:0] status;

  always #2 clk = ~clk;

  opstage_nzp dut_i (
    .clk(clk), .rst_n(rst_n), .valid(valid), .instr(instr), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .ld_en(ld_en), .ld_data(ld_data), .result(result),
    .dst_idx(dst_idx), .src1_idx(src1_idx), .src2_idx(src2_idx),
    .wr_en(wr_en), .status(status)
  );

  typedef struct {
    logic [15:0] res;
    logic        we;
    logic [8:0]  idx;
    logic [15:0] st;
    string       tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] exp_cc = 3'b010;
  bit done = 0;

  function automatic logic [2:0] nzp(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [15:0] ins, input logic [15:0] a,
                       input logic [15:0] b, input logic le, input logic [15:0] ld,
                       input string tag);
    item_t it;
    logic [15:0] sb, r;
    logic op;
    @(negedge clk);
    valid = v; instr = ins; opnd_a = a; opnd_b = b; ld_en = le; ld_data = ld;
    sb = ins[5] ? {{11{ins[4]}}, ins[4:0]} : b;
    op = 1'b1;
    case (ins[15:12])
      4'b0001: r = a + sb;
      4'b0101: r = a & sb;
      4'b1001: r = ~a;
      default: begin r = 16'h0; op = 1'b0; end
    endcase
    it.res = r;
    it.we  = v & op;
    it.idx = {ins[11:9], ins[8:6], ins[2:0]};
    if (le) exp_cc = nzp(ld);
    else if (it.we) exp_cc = nzp(r);
    it.st  = {1'b1, 4'b0, 3'd0, 5'b0, exp_cc};
    it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        if (it.we) check({it.tag, " result"}, result, it.res);
        check({it.tag, " wr_en"}, {15'b0, wr_en}, {15'b0, it.we});
        check({it.tag, " idx R5"}, {7'b0, dst_idx, src1_idx, src2_idx}, {7'b0, it.idx});
        check({it.tag, " status"}, status, it.st);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset status", status, 16'h8002);
    check("R6 idle wr_en", {15'b0, wr_en}, 16'h0);
    // ADD r1 = r2 + r3 ; ADD reg: 0001 001 010 000 011
    drive(1, 16'h1283, 16'd5, 16'd7, 0, 0, "R1 add reg P");
    drive(1, 16'h1283, 16'hFFFF, 16'h0001, 0, 0, "R1 add wrap Z R7");
    drive(1, 16'h8000 ^ 16'h8000 | 16'h1AB0, 16'd3, 16'h1234, 0, 0, "R2 add lit -16 N");
    drive(1, 16'h1AAF, 16'd1, 16'h9999, 0, 0, "R2 add lit 15 P");
    drive(1, 16'h5E45, 16'hF0F0, 16'h3C3C, 0, 0, "R3 and reg P");
    drive(1, 16'h5E45, 16'h0F0F, 16'hF0F0, 0, 0, "R3 and reg Z");
    drive(1, 16'h567F, 16'hA5A5, 16'h0000, 0, 0, "R2 and lit -1 N");
    drive(1, 16'h5665, 16'hFFFF, 16'h0000, 0, 0, "R2 and lit 5 P");
    drive(1, 16'h9BBF, 16'hFFFF, 16'h1111, 0, 0, "R4 not to zero Z");
    drive(1, 16'h9BBF, 16'h0000, 16'h1111, 0, 0, "R4 not to ones N");
    drive(1, 16'h0E3F, 16'h0001, 16'h0001, 0, 0, "R6 R9 branch opcode no write");
    drive(1, 16'h6283, 16'h0001, 16'h0001, 0, 0, "R6 R9 load opcode no write");
    drive(0, 16'h1283, 16'h0001, 16'h0001, 0, 0, "R6 R9 not valid");
    drive(0, 16'h0000, 16'h0, 16'h0, 1, 16'h0042, "R8 load P");
    drive(0, 16'h0000, 16'h0, 16'h0, 1, 16'h0000, "R8 load Z");
    drive(0, 16'h0000, 16'h0, 16'h0, 1, 16'h8001, "R8 load N");
    drive(1, 16'h1283, 16'd5, 16'd7, 1, 16'h0000, "R8 load wins over add");
    drive(1, 16'h1283, 16'h7FFF, 16'h0001, 0, 0, "R1 add to 8000 N R7");
    drive(0, 16'h0000, 16'h0, 16'h0, 0, 0, "R9 idle hold");
    drive(1, 16'h1FFF, 16'h0010, 16'h0, 0, 0, "R2 add lit -1 P R5");
    drive(1, 16'hD000, 16'h0, 16'h0, 0, 0, "R6 unused opcode");
    drive(0, 16'h0000, 16'h0, 16'h0, 0, 0, "R9 idle end");
    repeat (3) @(negedge clk);
    check("R9 queue drained", 16'(q.size()), 16'h0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule